// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

A programmable binary counter of parameterised width (four bits by default) that counts up or down. It has no direction pin. Two separate active-low count strobes set the direction: a pulse on one strobe steps the count up, and a pulse on the other steps it down. A single system clock samples both strobes. A count is taken when a strobe is seen going from low to high between two consecutive samples. All state bits update together on that clock edge.

The block also has a parallel preset, loaded while an active-low load input is held low, and a clear that overrides everything else. It has two active-low terminal flags. The carry flag is low while the up strobe is low and the count is at its maximum. The borrow flag is low while the down strobe is low and the count is zero. Each flag pulse therefore lasts as long as the strobe that causes it. Wiring carry to the next stage's up strobe and borrow to the next stage's down strobe chains stages with no glue logic. Presetting a start value shortens the count length, so the counter can serve as a divide-by-N.

The asynchronous reset is asserted at once and released through a two-flop synchroniser.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 without waiting for a clock edge. With both strobes high, `carry_n` and `borrow_n` are 1.
- R2: A rising edge on `up_n` adds one to `count` at the clock edge that first samples `up_n` high after a sample of it low. This needs `dn_n` to show no rising edge at that same sample, `clr` to be low and `load_n` to be high.
- R3: Under the same conditions, a rising edge on `dn_n` subtracts one from `count`.
- R4: The count wraps from the all-ones value (15) to 0 when counting up, and from 0 to 15 when counting down.
- R5: When `clr` is 1 at a clock edge, `count` becomes 0. This overrides both load and any strobe edge.
- R6: While `load_n` is 0 and `clr` is 0, each clock edge copies `preset` into `count`. Strobe edges seen while `load_n` is 0 are ignored and are not replayed later.
- R7: When both strobes show a rising edge on the same sample, `count` holds its value.
- R8: `carry_n` is 0 exactly while `up_n` is 0 and `count` is 15, and is 1 otherwise. It follows `up_n` without a clock delay.
- R9: `borrow_n` is 0 exactly while `dn_n` is 0 and `count` is 0, and is 1 otherwise. It follows `dn_n` without a clock delay.
- R10: Two stages on one clock, with the first stage's `carry_n` driving the second stage's `up_n` and its `borrow_n` driving the second's `dn_n`, together count as one counter twice as wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load_n | input | 1 | Active-low parallel load enable |
| preset | input | WIDTH | Value loaded while `load_n` is low |
| up_n | input | 1 | Active-low count-up strobe |
| dn_n | input | 1 | Active-low count-down strobe |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low overflow flag |
| borrow_n | output | 1 | Active-low underflow flag |

## Verification
The embedded properties check on every cycle:
- the priority between clear, load and count;
- the step of exactly one after a lone strobe edge;
- the hold when both strobes rise together;
- that an asserted terminal flag always matches the terminal count.

Only the bench's scenarios show the full behaviour at the ports. These include:
- wide flag pulses that last as long as the strobe;
- a strobe edge swallowed during load and never replayed;
- an asynchronous reset in the middle of a run;
- a two-stage chain whose joint value matches the net number of up and down pulses.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } op_e;

  localparam int unsigned STROBE_CNT = 2;
  localparam int unsigned STB_UP     = 0;
  localparam int unsigned STB_DN     = 1;
endpackage

// File: rtl/dsc_reset_sync.sv
module dsc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_edge_detect.sv
module dsc_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = strobe_n;
    rise   = strobe_n & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  // R2
  edge_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !$past(strobe_n));
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_rise,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  op_e              op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    if (clr)                     op = OP_CLEAR;
    else if (!load_n)            op = OP_LOAD;
    else if (up_rise && !dn_rise) op = OP_INC;
    else if (dn_rise && !up_rise) op = OP_DEC;
    else                         op = OP_HOLD;
  end

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = preset;
      OP_INC:   cnt_d = cnt_q + ONE;
      OP_DEC:   cnt_d = cnt_q - ONE;
      default:  cnt_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R6
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (count == $past(preset)));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && !dn_rise) |=> (count == WIDTH'($past(count) + ONE)));
  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dn_rise && !up_rise) |=> (count == WIDTH'($past(count) - ONE)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && (up_rise == dn_rise)) |=> $stable(count));
endmodule

// File: rtl/dsc_term_flags.sv
module dsc_term_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_n,
  input  logic             dn_n,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic at_top;
  logic at_bottom;

  always_comb begin
    at_top    = (count == TOP);
    at_bottom = (count == '0);
    carry_n   = ~(~up_n & at_top);
    borrow_n  = ~(~dn_n & at_bottom);
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_n,
  input  logic             dn_n,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic                  rst_n_s;
  logic [STROBE_CNT-1:0] strobe_n;
  logic [STROBE_CNT-1:0] rise;

  assign strobe_n[STB_UP] = up_n;
  assign strobe_n[STB_DN] = dn_n;

  dsc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  for (genvar g = 0; g < STROBE_CNT; g++) begin : g_edge
    dsc_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .strobe_n (strobe_n[g]),
      .rise     (rise[g])
    );
  end

  dsc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (clr),
    .load_n  (load_n),
    .preset  (preset),
    .up_rise (rise[STB_UP]),
    .dn_rise (rise[STB_DN]),
    .count   (count)
  );

  dsc_term_flags #(.WIDTH(WIDTH)) u_flags (
    .count    (count),
    .up_n     (up_n),
    .dn_n     (dn_n),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // R8
  carry_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !carry_n |-> (count == {WIDTH{1'b1}}));
  // R9
  borrow_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !borrow_n |-> (count == '0));
endmodule

// File: tb/sim_dual_strobe_counter.sv
module sim_dual_strobe_counter;
  localparam int W = 4;
  localparam int NV = 25;
  // fields: [15]clr [14]load_n [13]up_n [12]dn_n [11:8]preset [7:4]count [3]carry_n [2]borrow_n
  localparam logic [15:0] VEC [NV] = '{
    16'h3DDC, 16'h50DC, 16'h70EC, 16'h50EC, 16'h70FC,
    16'h50F4, 16'h50F4, 16'h700C, 16'h6008, 16'h70FC,
    16'h60FC, 16'h70EC, 16'h40EC, 16'h70EC, 16'h50EC,
    16'h355C, 16'h705C, 16'hB90C, 16'h3FFC, 16'h50F4,
    16'hF00C, 16'h6008, 16'h233C, 16'h603C, 16'h702C
  };
  localparam logic [8*NV-1:0] TAGS =
    {"2","2","2","2","2","8","8","4","9","4",
     "9","3","7","7","6","6","6","5","6","8",
     "5","9","6","6","3"};

  logic clk = 1'b0;
  logic rst_n, clr, load_n, up_n, dn_n;
  logic [W-1:0] preset, count, count1;
  logic carry_n, borrow_n, carry1_n, borrow1_n;
  int applied = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  dual_strobe_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
    .up_n(up_n), .dn_n(dn_n), .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

  dual_strobe_counter #(.WIDTH(W)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(1'b1), .preset('0),
    .up_n(carry_n), .dn_n(borrow_n), .count(count1), .carry_n(carry1_n), .borrow_n(borrow1_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_up();
    up_n = 1'b0; step(); up_n = 1'b1; step();
  endtask

  task automatic pulse_dn();
    dn_n = 1'b0; step(); dn_n = 1'b1; step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; load_n = 1'b1; up_n = 1'b1; dn_n = 1'b1; preset = '0;
    repeat (3) step();
    // R1 reset state
    check("R1", {4'h0, count}, 8'h00);
    check("R1", {6'h0, carry_n, borrow_n}, 8'h03);
    rst_n = 1'b1;
    repeat (4) step();

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      string tag;
      v = VEC[i];
      {clr, load_n, up_n, dn_n} = v[15:12];
      preset = v[11:8];
      step();
      tag = $sformatf("R%s", string'(TAGS[8*(NV-1-i) +: 8]));
      check(tag, {4'h0, count}, {4'h0, v[7:4]});
      check(tag, {6'h0, carry_n, borrow_n}, {6'h0, v[3:2]});
    end

    // R1 asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R1", {4'h0, count}, 8'h00);
    step(); rst_n = 1'b1; repeat (4) step();

    // R10 cascade: clear both, 40 up then 20 down pulses => 20
    clr = 1'b1; step(); clr = 1'b0; step();
    for (int k = 0; k < 40; k++) pulse_up();
    check("R10", {count1, count}, 8'h28);
    for (int k = 0; k < 20; k++) pulse_dn();
    check("R10", {count1, count}, 8'h14);

    // R4 wrap down from zero via load
    load_n = 1'b0; preset = 4'h0; step(); load_n = 1'b1;
    pulse_dn();
    check("R4", {4'h0, count}, 8'h0F);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule